// File: doc/BRIEF.md
# Dual-Edge Multicycle Step Controller

This block sequences one instruction at a time through five steps: instruction fetch, operand fetch, decode, execute and result write-back. A binary step index selects the active step. The index moves forward on every clock edge, rising and falling. A plain four-step instruction therefore completes in two clock periods. Dual-edge stepping uses one register bank clocked on the rising edge and one on the falling edge. The two banks are combined into the live value. No clock is gated or inverted into a new clock net.

The two top bits of the fetched instruction word choose which steps run. When the word is captured, those bits are latched along with the rest of the word. For the rest of the instruction they steer the sequence and the datapath enables. The lower bits of the latched word are passed to the datapath as an operand field. The fetch step waits on a memory-ready input. Every other step takes exactly one edge.

Top module: `dual_edge_step_ctrl`

## Requirements
- R1: Steps run in the fixed order fetch, operand fetch, decode, execute, write-back. Each instruction returns to fetch after its last step. Step strobe bit positions are 0 fetch, 1 operand fetch, 2 decode, 3 execute, 4 write-back.
- R2: The step index advances on every rising and every falling clock edge. An instruction with class bits 2'b01 shows fetch, decode, execute and write-back on four consecutive edges, which is two clock periods.
- R3: Instruction word bit [INSTR_W-1] marks a memory operand. When it is 0, operand fetch is skipped and fetch goes directly to decode.
- R4: Instruction word bit [INSTR_W-2] marks a result. When it is 0, write-back is skipped and execute returns directly to fetch.
- R5: Fetch holds while memReady is low. The instruction word is captured on the first edge, of either polarity, that samples memReady high, and the step advances on that same edge.
- R6: Outside reset, exactly one step strobe is high at all times.
- R7: Reset is synchronous and must be held for at least one full clock period. While reset is high, all strobes and enables are 0. After reset is released the controller shows fetch, whichever step it was in when reset arrived. The latched word is cleared to zero.
- R8: The enables follow the step and the latched class bits. aluEn is high in execute. memWriteEn is high in execute when the class bits are 2'b10. regWriteEn is high in write-back. wbFromMem is high in write-back when the memory bit is 1.
- R9: Changes on instrWord outside the capture edge have no effect on the current instruction. Changes on memReady outside fetch also have no effect. The step sequence, the enables and irOperand all follow the latched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges advance the step |
| rst | input | 1 | Synchronous reset, active high, held for at least one period |
| memReady | input | 1 | Memory has the instruction word ready during fetch |
| instrWord | input | INSTR_W | Instruction word from memory; top two bits are the class |
| phaseStrobe | output | 5 | One-hot step strobes (bit 0 fetch … bit 4 write-back) |
| aluEn | output | 1 | Execute-unit enable |
| memWriteEn | output | 1 | Memory write enable for store-class instructions |
| regWriteEn | output | 1 | Register write enable in write-back |
| wbFromMem | output | 1 | Write-back data taken from memory rather than the execute unit |
| irOperand | output | INSTR_W-2 | Lower field of the latched instruction word |

## Verification
All four class encodings are run. Together they separate the operand-fetch skip from the write-back skip, and store-only write enables from load write-back selection. Fetch wait counts of zero and odd values move the capture onto rising and falling edges in turn, which shows that both register banks load correctly. The instruction word is inverted and memReady is held high during the non-fetch steps, so a design that re-reads the live word shows up as wrong enables or a wrong operand field. A reset issued in the middle of a load-class instruction checks the return to fetch with all outputs quiet.

// File: rtl/step_ctrl_pkg.sv
package step_ctrl_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_FETCH  = 3'd0,
    PH_OPND   = 3'd1,
    PH_DECODE = 3'd2,
    PH_EXEC   = 3'd3,
    PH_WBACK  = 3'd4
  } phase_e;

  // bit 0 is fetch, bit 4 is write-back
  typedef struct packed {
    logic wback;
    logic exec;
    logic decode;
    logic opnd;
    logic fetch;
  } strobe_t;

endpackage

// File: rtl/dual_edge_reg.sv
// Register that loads on both clock edges: each bank stores the new value
// folded with the other bank, and the visible value is their XOR.
module dual_edge_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] riseBank;
  logic [W-1:0] fallBank;

  always_ff @(posedge clk) begin
    if (rst)       riseBank <= '0;
    else if (load) riseBank <= d ^ fallBank;
  end

  always_ff @(negedge clk) begin
    if (rst)       fallBank <= '0;
    else if (load) fallBank <= d ^ riseBank;
  end

  assign q = riseBank ^ fallBank;

endmodule

// File: rtl/step_control.sv
module step_control
  import step_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    memReady,
  input  logic    liveMemBit,
  input  logic    heldResultBit,
  output strobe_t strobes,
  output logic    captureWord
);

  logic [PHASE_W-1:0] stepRaw;
  logic [PHASE_W-1:0] stepNext;
  phase_e             step;

  dual_edge_reg #(.W(PHASE_W)) uStep (
    .clk (clk),
    .rst (rst),
    .load(1'b1),
    .d   (stepNext),
    .q   (stepRaw)
  );

  assign step = phase_e'(stepRaw);

  always_comb begin
    unique case (step)
      PH_FETCH:  stepNext = memReady ? (liveMemBit ? PH_OPND : PH_DECODE) : PH_FETCH;
      PH_OPND:   stepNext = PH_DECODE;
      PH_DECODE: stepNext = PH_EXEC;
      PH_EXEC:   stepNext = heldResultBit ? PH_WBACK : PH_FETCH;
      PH_WBACK:  stepNext = PH_FETCH;
      default:   stepNext = PH_FETCH;
    endcase
  end

  always_comb begin
    strobes = '0;
    if (!rst) begin
      strobes.fetch  = (step == PH_FETCH);
      strobes.opnd   = (step == PH_OPND);
      strobes.decode = (step == PH_DECODE);
      strobes.exec   = (step == PH_EXEC);
      strobes.wback  = (step == PH_WBACK);
    end
  end

  assign captureWord = !rst && (step == PH_FETCH) && memReady;

  AST_ONE_STEP_RISE: assert property (@(posedge clk) disable iff (rst) $onehot(strobes)); // R6
  AST_ONE_STEP_FALL: assert property (@(negedge clk) disable iff (rst) $onehot(strobes)); // R6
  AST_WBACK_HAS_RESULT: assert property (@(posedge clk) disable iff (rst) strobes.wback |-> heldResultBit); // R4

endmodule

// File: rtl/datapath_ctl.sv
module datapath_ctl
  import step_ctrl_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               captureWord,
  input  strobe_t            strobes,
  output logic               heldMemBit,
  output logic               heldResultBit,
  output logic               aluEn,
  output logic               memWriteEn,
  output logic               regWriteEn,
  output logic               wbFromMem,
  output logic [INSTR_W-3:0] irOperand
);

  localparam int MEM_BIT = INSTR_W - 1;
  localparam int RES_BIT = INSTR_W - 2;

  logic [INSTR_W-1:0] heldWord;

  dual_edge_reg #(.W(INSTR_W)) uWord (
    .clk (clk),
    .rst (rst),
    .load(captureWord),
    .d   (instrWord),
    .q   (heldWord)
  );

  assign heldMemBit    = heldWord[MEM_BIT];
  assign heldResultBit = heldWord[RES_BIT];
  assign irOperand     = heldWord[RES_BIT-1:0];

  assign aluEn      = strobes.exec;
  assign memWriteEn = strobes.exec && heldMemBit && !heldResultBit;
  assign regWriteEn = strobes.wback;
  assign wbFromMem  = strobes.wback && heldMemBit;

  AST_OPND_NEEDS_MEM_RISE: assert property (@(posedge clk) disable iff (rst) strobes.opnd |-> heldMemBit); // R3
  AST_OPND_NEEDS_MEM_FALL: assert property (@(negedge clk) disable iff (rst) strobes.opnd |-> heldMemBit); // R3
  AST_MEMSEL_HAS_RESULT: assert property (@(negedge clk) disable iff (rst) wbFromMem |-> heldResultBit); // R8

endmodule

// File: rtl/dual_edge_step_ctrl.sv
module dual_edge_step_ctrl
  import step_ctrl_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               memReady,
  input  logic [INSTR_W-1:0] instrWord,
  output logic [4:0]         phaseStrobe,
  output logic               aluEn,
  output logic               memWriteEn,
  output logic               regWriteEn,
  output logic               wbFromMem,
  output logic [INSTR_W-3:0] irOperand
);

  strobe_t strobes;
  logic    captureWord;
  logic    heldMemBit;
  logic    heldResultBit;

  step_control uCtl (
    .clk          (clk),
    .rst          (rst),
    .memReady     (memReady),
    .liveMemBit   (instrWord[INSTR_W-1]),
    .heldResultBit(heldResultBit),
    .strobes      (strobes),
    .captureWord  (captureWord)
  );

  datapath_ctl #(.INSTR_W(INSTR_W)) uDp (
    .clk          (clk),
    .rst          (rst),
    .instrWord    (instrWord),
    .captureWord  (captureWord),
    .strobes      (strobes),
    .heldMemBit   (heldMemBit),
    .heldResultBit(heldResultBit),
    .aluEn        (aluEn),
    .memWriteEn   (memWriteEn),
    .regWriteEn   (regWriteEn),
    .wbFromMem    (wbFromMem),
    .irOperand    (irOperand)
  );

  assign phaseStrobe = strobes;

  AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> (phaseStrobe == 5'b0 && !memWriteEn && !regWriteEn)); // R7

endmodule

// File: tb/sim_dual_edge_step_ctrl.sv
module sim_dual_edge_step_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic memReady = 1'b0;
  logic [IW-1:0] instrWord = '0;
  logic [4:0] phaseStrobe;
  logic aluEn, memWriteEn, regWriteEn, wbFromMem;
  logic [IW-3:0] irOperand;

  dual_edge_step_ctrl #(.INSTR_W(IW)) u0 (
    .clk(clk), .rst(rst), .memReady(memReady), .instrWord(instrWord),
    .phaseStrobe(phaseStrobe), .aluEn(aluEn), .memWriteEn(memWriteEn),
    .regWriteEn(regWriteEn), .wbFromMem(wbFromMem), .irOperand(irOperand)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [4:0]    ph;
    logic [3:0]    en;
    logic [IW-3:0] op;
    bit            chkOp;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int mPhase = 0;
  logic [IW-1:0] mIr = '0;

  // expected outputs for the model step (R8: {alu, memWrite, regWrite, wbFromMem})
  function automatic exp_t modelOut(string tag);
    exp_t e;
    e.ph = 5'b1 << mPhase;
    e.en = {mPhase == 3, mPhase == 3 && mIr[IW-1] && !mIr[IW-2],
            mPhase == 4, mPhase == 4 && mIr[IW-1]};
    e.op = mIr[IW-3:0];
    e.chkOp = 1'b1;
    e.tag = tag;
    return e;
  endfunction

  // drive inputs for the coming edge and queue the window that follows it
  task automatic drive(bit r, bit rdy, logic [IW-1:0] w, string tag);
    exp_t e;
    @(posedge clk or negedge clk);
    #2;
    rst = r;
    memReady = rdy;
    instrWord = w;
    if (r) begin
      mPhase = 0;
      mIr = '0;
      e.ph = '0; e.en = '0; e.op = '0; e.chkOp = 1'b0; e.tag = tag;
    end else begin
      case (mPhase)
        0: if (rdy) begin mIr = w; mPhase = w[IW-1] ? 1 : 2; end
        1: mPhase = 2;
        2: mPhase = 3;
        3: mPhase = mIr[IW-2] ? 4 : 0;
        default: mPhase = 0;
      endcase
      e = modelOut(tag);
    end
    expQ.push_back(e);
  endtask

  task automatic runInstr(logic [1:0] cls, logic [IW-3:0] op, int waits, string tag);
    logic [IW-1:0] w;
    int n;
    w = {cls, op};
    for (int i = 0; i < waits; i++) drive(1'b0, 1'b0, ~w, tag);      // R5 hold
    drive(1'b0, 1'b1, w, tag);
    n = int'(cls[1]) + 2 + int'(cls[0]);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, ~w ^ IW'(i), tag); // R9 live word ignored
  endtask

  // monitor: pops one expected window per edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk or negedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (phaseStrobe !== e.ph || {aluEn, memWriteEn, regWriteEn, wbFromMem} !== e.en ||
            (e.chkOp && irOperand !== e.op)) begin
          fails++;
          $display("FAIL %s: ph=%b en=%b op=%h expected ph=%b en=%b op=%h",
                   e.tag, phaseStrobe, {aluEn, memWriteEn, regWriteEn, wbFromMem}, irOperand,
                   e.ph, e.en, e.op);
        end
        if (e.ph != 0) begin
          checks++;
          if ($countones(phaseStrobe) != 1) begin
            fails++;
            $display("FAIL R6: ph=%b expected exactly one bit set", phaseStrobe);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, "R7 reset quiet");
    runInstr(2'b01, 14'h0123, 0, "R2 R1 R8 alu four edges");
    runInstr(2'b11, 14'h0abc, 3, "R5 R1 R8 load odd wait");
    runInstr(2'b10, 14'h1555, 0, "R4 R8 store");
    runInstr(2'b00, 14'h2aaa, 1, "R3 R4 plain");
    runInstr(2'b01, 14'h3fff, 2, "R9 R2 alu even wait");
    runInstr(2'b10, 14'h0001, 1, "R9 R8 store falling capture");
    // reset in the middle of a load
    drive(1'b0, 1'b1, {2'b11, 14'h1234}, "R7 load start");
    drive(1'b0, 1'b1, '1, "R7 load opfetch");
    drive(1'b1, 1'b1, '1, "R7 mid reset");
    drive(1'b1, 1'b1, '1, "R7 mid reset");
    runInstr(2'b11, 14'h0f0f, 0, "R7 R1 load after reset");
    runInstr(2'b00, 14'h00ff, 0, "R3 back to back");
    runInstr(2'b01, 14'h3c3c, 0, "R2 back to back");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, '1, "R5 idle hold");
    repeat (3) @(posedge clk or negedge clk);
    #3;
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d windows left unchecked, expected 0", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule